// File: doc/BRIEF.md
# Triggered Nibble Sequence Port

This block presents a whole time/date record to a host through one narrow bus location. The host writes to that location to start a transfer. At that write the block freezes a copy of the 64-bit record coming from a local time source, and it moves its read position back to the first nibble. Each read that follows returns one 4-bit nibble of the frozen copy, starting with the least-significant nibble and ending with the most-significant one.

The read and write strobes come from an address decoder outside the block. They are asynchronous, active-high events. Inside the block each strobe is synchronized to the local clock and edge-detected. The data bus is driven only while a read is in progress and is high-impedance at all other times. The read position moves forward when the read strobe is released, so the nibble on the bus holds steady for as long as the strobe is asserted.

Top module: `nibble_seq_port`

## Requirements
- R1: After reset the bus is not driven (`busOe` low). Any read before the first write returns 4'hF.
- R2: A write copies `recordIn` into a snapshot. Changes on `recordIn` after that write have no effect on any nibble that is read out.
- R3: After a write, the next read returns nibble 0 of the snapshot.
- R4: Read k after a write (k counted from 0) returns snapshot bits [4k+3:4k], so the least-significant nibble comes first.
- R5: Once all 16 nibbles have been read, every further read returns 4'hF until the next write.
- R6: `busOe` is high only while a synchronized read strobe is asserted. `busData` is high-impedance whenever `busOe` is low.
- R7: The nibble on `busData` stays stable for the whole time a read strobe is held, even when the strobe is long.
- R8: One read access moves the read position forward by exactly one, whatever the length of the strobe.
- R9: A write made partway through a read-out restarts the sequence at nibble 0, using the newly captured record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | input | 1 | Decoded read strobe, active high, asynchronous |
| wrReq | input | 1 | Decoded write strobe, active high, asynchronous |
| recordIn | input | 64 | Live time/date record from the time source |
| busData | output | 4 | Tri-state nibble output |
| busOe | output | 1 | High while the block drives `busData` |

## Verification
The hardest cases to reach from the ports happen late in a read-out. One is a fresh write that interrupts a read-out already partway through. The other is the exhausted state after the sixteenth read, which can only be reached by a long run of complete read accesses. The bench drives full strobe cycles through the synchronizer and walks past the end of the record to reach these states. It also holds one strobe for many clocks while changing the live record, which shows that neither the bus value nor the read position moves.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;   // take a snapshot and restart the sequence
    logic advance;   // step to the next nibble
    logic driveOut;  // enable the bus output
  } nspCtrl_t;
endpackage

// File: rtl/nsp_sync_edge.sv
module nsp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shiftQ;
  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      prevQ  <= 1'b0;
    end else begin
      shiftQ <= {shiftQ[STAGES-2:0], asyncIn};
      prevQ  <= shiftQ[STAGES-1];
    end
  end

  assign level = shiftQ[STAGES-1];
  assign rise  = level & ~prevQ;
  assign fall  = ~level & prevQ;
endmodule

// File: rtl/nsp_ctrl.sv
module nsp_ctrl
  import nsp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdReq,
  input  logic     wrReq,
  output nspCtrl_t ctrl
);
  localparam int NUM_STROBES = 2;
  localparam int RD_IDX = 0;
  localparam int WR_IDX = 1;

  logic [NUM_STROBES-1:0] reqIn;
  logic [NUM_STROBES-1:0] reqLevel;
  logic [NUM_STROBES-1:0] reqRise;
  logic [NUM_STROBES-1:0] reqFall;

  assign reqIn = {wrReq, rdReq};

  for (genvar g = 0; g < NUM_STROBES; g++) begin : gSync
    nsp_sync_edge #(.STAGES(SYNC_STAGES)) uSync (
      .clk    (clk),
      .rstN   (rstN),
      .asyncIn(reqIn[g]),
      .level  (reqLevel[g]),
      .rise   (reqRise[g]),
      .fall   (reqFall[g])
    );
  end

  logic unusedBits;
  assign unusedBits = reqLevel[WR_IDX] ^ reqFall[WR_IDX] ^ reqRise[RD_IDX];

  always_comb begin
    ctrl.capture  = reqRise[WR_IDX];
    // a write restarting the sequence wins over a read release in the same cycle
    ctrl.advance  = reqFall[RD_IDX] & ~reqRise[WR_IDX];
    ctrl.driveOut = reqLevel[RD_IDX];
  end
endmodule

// File: rtl/nsp_datapath.sv
module nsp_datapath
  import nsp_pkg::*;
#(
  parameter int NIBBLE_W    = 4,
  parameter int NUM_NIBBLES = 16,
  localparam int REC_W = NIBBLE_W * NUM_NIBBLES,
  localparam int PTR_W = $clog2(NUM_NIBBLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  nspCtrl_t            ctrl,
  input  logic [REC_W-1:0]    recordIn,
  output logic [NIBBLE_W-1:0] nibbleOut,
  output logic                outEnable,
  output logic [PTR_W-1:0]    ptrOut,
  output logic [REC_W-1:0]    snapOut
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_NIBBLES);

  logic [REC_W-1:0] snapQ;
  logic [PTR_W-1:0] ptrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapQ <= '0;
      ptrQ  <= PTR_END;
    end else if (ctrl.capture) begin
      snapQ <= recordIn;
      ptrQ  <= '0;
    end else if (ctrl.advance && (ptrQ != PTR_END)) begin
      ptrQ <= ptrQ + PTR_W'(1);
    end
  end

  always_comb begin
    nibbleOut = '1;
    for (int i = 0; i < NUM_NIBBLES; i++) begin
      if (ptrQ == PTR_W'(i)) nibbleOut = snapQ[i*NIBBLE_W +: NIBBLE_W];
    end
  end

  assign outEnable = ctrl.driveOut;
  assign ptrOut    = ptrQ;
  assign snapOut   = snapQ;
endmodule

// File: rtl/nibble_seq_port.sv
module nibble_seq_port
  import nsp_pkg::*;
#(
  parameter int NIBBLE_W    = 4,
  parameter int NUM_NIBBLES = 16,
  parameter int SYNC_STAGES = 2,
  localparam int REC_W = NIBBLE_W * NUM_NIBBLES,
  localparam int PTR_W = $clog2(NUM_NIBBLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdReq,
  input  logic                wrReq,
  input  logic [REC_W-1:0]    recordIn,
  output logic [NIBBLE_W-1:0] busData,
  output logic                busOe
);
  nspCtrl_t            ctrl;
  logic [NIBBLE_W-1:0] nibble;
  logic                outEnable;
  logic [PTR_W-1:0]    ptr;
  logic [REC_W-1:0]    snapshot;

  nsp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .rdReq(rdReq),
    .wrReq(wrReq),
    .ctrl (ctrl)
  );

  nsp_datapath #(.NIBBLE_W(NIBBLE_W), .NUM_NIBBLES(NUM_NIBBLES)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .recordIn (recordIn),
    .nibbleOut(nibble),
    .outEnable(outEnable),
    .ptrOut   (ptr),
    .snapOut  (snapshot)
  );

  assign busOe   = outEnable;
  assign busData = outEnable ? nibble : 'z;
endmodule

// File: rtl/nsp_checker.sv
module nsp_checker
  import nsp_pkg::*;
#(
  parameter int NIBBLE_W    = 4,
  parameter int NUM_NIBBLES = 16,
  localparam int REC_W = NIBBLE_W * NUM_NIBBLES,
  localparam int PTR_W = $clog2(NUM_NIBBLES + 1)
) (
  input logic                clk,
  input logic                rstN,
  input nspCtrl_t            ctrl,
  input logic [PTR_W-1:0]    ptr,
  input logic [REC_W-1:0]    snapshot,
  input logic [NIBBLE_W-1:0] nibble,
  input logic                busOe
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_NIBBLES);

  assert_snapshot_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(snapshot));

  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> (ptr == '0));

  assert_fill_saturate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ptr == PTR_END) && !ctrl.capture |=> (ptr == PTR_END));

  assert_stable_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    busOe && $past(busOe) && !$past(ctrl.capture) |-> $stable(nibble));

  assert_single_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance && (ptr != PTR_END) |=> (ptr == $past(ptr) + PTR_W'(1)));

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_END);
endmodule

bind nibble_seq_port nsp_checker #(.NIBBLE_W(NIBBLE_W), .NUM_NIBBLES(NUM_NIBBLES)) uChecker (
  .clk     (clk),
  .rstN    (rstN),
  .ctrl    (ctrl),
  .ptr     (ptr),
  .snapshot(snapshot),
  .nibble  (nibble),
  .busOe   (busOe)
);

// File: tb/tb_nibble_seq_port.sv
module tb_nibble_seq_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReq = 1'b0;
  logic        wrReq = 1'b0;
  logic [63:0] recordIn = '0;
  logic [3:0]  busData;
  logic        busOe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nibble_seq_port dut (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq),
    .recordIn(recordIn), .busData(busData), .busOe(busOe)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nib(input logic [63:0] rec, input int k);
    return rec[4*k +: 4];
  endfunction

  task automatic doWrite(input logic [63:0] rec);
    recordIn = rec;
    @(negedge clk);
    wrReq = 1'b1;
    repeat (4) @(negedge clk);
    wrReq = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // one complete read access; returns the value seen while the strobe is held
  task automatic doRead(input string req, input logic [3:0] exp);
    rdReq = 1'b1;
    repeat (4) @(negedge clk);
    check({req, " oe"}, {3'b0, busOe}, 4'h1);
    check(req, busData, exp);
    rdReq = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 oe low after read", {3'b0, busOe}, 4'h0);
  endtask

  task automatic testReset();
    check("R1 oe low after reset", {3'b0, busOe}, 4'h0);
    doRead("R1 read before write", 4'hF);
  endtask

  task automatic testFullSequence();
    logic [63:0] rec = 64'hFEDC_BA98_7654_3210;
    doWrite(rec);
    check("R6 oe low after write", {3'b0, busOe}, 4'h0);
    for (int k = 0; k < 16; k++) doRead(k == 0 ? "R3 first nibble" : "R4 sequence", nib(rec, k));
    doRead("R5 past end", 4'hF);
    doRead("R5 past end again", 4'hF);
  endtask

  task automatic testSnapshot();
    logic [63:0] rec = 64'h0123_4567_89AB_CDEF;
    doWrite(rec);
    recordIn = 64'h5A5A_A5A5_3C3C_C3C3;
    for (int k = 0; k < 16; k++) doRead("R2 snapshot held", nib(rec, k));
    doRead("R5 fill after snapshot", 4'hF);
  endtask

  task automatic testRestart();
    logic [63:0] recA = 64'h1111_2222_3333_4444;
    logic [63:0] recB = 64'h1357_9BDF_0246_8ACE;
    doWrite(recA);
    for (int k = 0; k < 5; k++) doRead("R4 partial", nib(recA, k));
    doWrite(recB);
    for (int k = 0; k < 3; k++) doRead("R9 restart", nib(recB, k));
  endtask

  task automatic testLongStrobe();
    logic [63:0] rec = 64'hA1B2_C3D4_E5F6_0789;
    doWrite(rec);
    rdReq = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 long strobe start", busData, nib(rec, 0));
    recordIn = ~rec;
    repeat (8) @(negedge clk);
    check("R7 long strobe middle", busData, nib(rec, 0));
    repeat (8) @(negedge clk);
    check("R7 long strobe end", busData, nib(rec, 0));
    rdReq = 1'b0;
    repeat (4) @(negedge clk);
    doRead("R8 single advance", nib(rec, 1));
    doRead("R8 next advance", nib(rec, 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testFullSequence();
    testSnapshot();
    testRestart();
    testLongStrobe();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule